// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a set of recent virtual-to-physical page translations and answers a lookup in the same cycle it is presented. A requester drives a virtual address, whether the access is a write, and whether the processor is in user mode. The block compares the virtual page number against every stored entry at once. A match that passes the access-rights check raises a hit and returns the physical address. A match that fails the check raises a protection fault. No match raises a miss.

After a miss, a page-table walker outside this block supplies the translation through the refill port. A new page goes into the slot named by a round-robin victim pointer. A page that is already held is overwritten where it sits. A flush input empties the buffer in one cycle. Each entry carries its own read, write and user-access permissions and a dirty flag. The first permitted write to a clean page sets the dirty flag.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid and the victim pointer is at entry 0, so every lookup misses.
- R2: On a hit, `lk_paddr` is the stored physical page number in bits 31:12 and the unchanged address bits 11:0 in bits 11:0. It is valid combinationally in the same cycle as the lookup.
- R3: `lk_hit` is high only when `lk_valid` is high, a valid entry's page tag equals `lk_vaddr[31:12]`, and the permission check passes.
- R4: `lk_miss` is high when `lk_valid` is high and no valid entry matches. While `lk_valid` is low, `lk_hit`, `lk_miss`, `lk_fault` and `lk_dirty` are all low.
- R5: A refill of a page number not currently held writes the entry at the victim pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0, so after ENTRIES further new pages the oldest one misses.
- R6: A read to an entry whose read permission is clear, or a write to an entry whose write permission is clear, raises `lk_fault` with `lk_hit` low.
- R7: A user-mode access (`lk_user`=1) to an entry whose user permission is clear raises `lk_fault`. A kernel-mode access ignores the user permission.
- R8: A write hit to an entry whose dirty flag is clear sets the flag at the next clock edge. `lk_dirty` shows the matched entry's stored dirty flag during any lookup that matches.
- R9: A refill whose page number is already held overwrites that entry in place and leaves the victim pointer unchanged.
- R10: `flush` clears every valid flag and returns the victim pointer to 0 at the next edge. When a refill arrives in the same cycle as `flush`, the flush wins and the refill is dropped.
- R11: A lookup in the same cycle as a refill or flush sees the contents held before that clock edge.
- R12: A write that misses or faults leaves the dirty flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No valid entry for the page |
| lk_fault | output | 1 | Entry found but access denied |
| lk_dirty | output | 1 | Stored dirty flag of the matched entry |
| lk_paddr | output | 32 | Translated physical address |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Virtual page number to install |
| rf_ppn | input | 20 | Physical page number to install |
| rf_rd | input | 1 | Read permission of the new entry |
| rf_wr | input | 1 | Write permission of the new entry |
| rf_usr | input | 1 | User-mode access permitted |
| rf_dirty | input | 1 | Initial dirty flag of the new entry |
| flush | input | 1 | Invalidate all entries |

## Verification
Two pairs of functions can land on the same clock edge: a lookup together with a refill of the same page, and a flush together with a refill. The bench provokes the first pair by presenting a lookup of page X while refilling X. That cycle must miss and the next must hit. It provokes the second pair by asserting flush and refill together, then looking up the refilled page, which must miss. A flush that coincides with a lookup is also driven, and that lookup must still hit on the old contents. A behavioural model that applies the flush-first and contents-before-edge rules judges every cycle.

// File: rtl/tlb_pkg.sv
// Package: shared types for the translation buffer.
// Assumes one page size per build and one mapping per entry.
package tlb_pkg;

    // Per-entry state and permission flags
    typedef struct packed {
        logic vld;   // entry holds a live translation
        logic rd;    // reads permitted
        logic wr;    // writes permitted
        logic usr;   // user-mode access permitted
        logic dty;   // page has been written
    } tlb_flags_t;

endpackage

// File: rtl/tlb_perm_check.sv
// Module: access-rights check on the matched entry.
// Decides, combinationally, whether the current access type and
// privilege mode are allowed by the selected entry's flags.
// Assumes the flags come from a single matched entry.
module tlb_perm_check
    import tlb_pkg::*;
(
    input  tlb_flags_t flags,
    input  logic       is_write,
    input  logic       is_user,
    output logic       allowed
);

    logic type_ok;
    logic mode_ok;

    // Access type must be granted by the matching permission flag
    always_comb begin
        type_ok = is_write ? flags.wr : flags.rd;
    end

    // User mode needs the user flag; kernel mode bypasses it
    always_comb begin
        mode_ok = !is_user || flags.usr;
    end

    // Both conditions together grant the access
    always_comb begin
        allowed = type_ok && mode_ok;
    end

endmodule

// File: rtl/tlb_victim_ptr.sv
// Module: round-robin victim pointer for refills of new pages.
// Advances by one on each allocating refill and wraps at ENTRIES-1.
// Returns to 0 on flush. Assumes ENTRIES >= 2.
module tlb_victim_ptr #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             clear,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Pointer register: reset and flush to 0, otherwise step with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_entry_array.sv
// Module: entry storage with parallel tag compare.
// Holds flags, page tag and physical page per entry and compares
// both the lookup page and the refill page against every entry.
// The selected fields are the OR of the matching entries, which
// assumes at most one entry matches. The top keeps that true by
// overwriting in place on a repeated refill.
// Per-entry write priority: flush, then refill, then dirty set.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] lk_match,
    output tlb_flags_t         sel_flags,
    output logic [PPN_W-1:0]   sel_ppn,
    input  logic [VPN_W-1:0]   rf_vpn,
    output logic [ENTRIES-1:0] rf_match,
    input  logic [ENTRIES-1:0] wr_en,
    input  tlb_flags_t         wr_flags,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic [ENTRIES-1:0] dirty_set,
    input  logic               flush
);

    tlb_flags_t       flg [ENTRIES];
    logic [VPN_W-1:0] tag [ENTRIES];
    logic [PPN_W-1:0] ppn [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Entry state update with flush > refill > dirty priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flg[i] <= '0;
                tag[i] <= '0;
                ppn[i] <= '0;
            end else if (flush) begin
                flg[i].vld <= 1'b0;
            end else if (wr_en[i]) begin
                flg[i] <= wr_flags;
                tag[i] <= rf_vpn;
                ppn[i] <= wr_ppn;
            end else if (dirty_set[i]) begin
                flg[i].dty <= 1'b1;
            end
        end

        // Tag compare for the lookup port
        always_comb begin
            lk_match[i] = flg[i].vld && (tag[i] == lk_vpn);
        end

        // Tag compare for the refill port
        always_comb begin
            rf_match[i] = flg[i].vld && (tag[i] == rf_vpn);
        end
    end

    // OR-select of the matching entry's fields
    always_comb begin
        sel_flags = '0;
        sel_ppn   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_flags = sel_flags | flg[i];
                sel_ppn   = sel_ppn | ppn[i];
            end
        end
    end

endmodule

// File: rtl/tlb_fa.sv
// Module: fully associative translation buffer (top).
// Lookup is combinational: hit, miss, fault and the physical
// address are valid in the cycle the address is presented.
// Refill, dirty update and flush take effect at the next edge.
// Assumes the walker refills only with a consistent mapping and
// that the lookup address does not change during a cycle.
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W = VA_W - PAGE_BITS,
    localparam int PPN_W = PA_W - PAGE_BITS,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic             lk_dirty,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_rd,
    input  logic             rf_wr,
    input  logic             rf_usr,
    input  logic             rf_dirty,
    input  logic             flush
);

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] rf_match;
    logic [ENTRIES-1:0] wr_en;
    logic [ENTRIES-1:0] dirty_set;
    tlb_flags_t         sel_flags;
    tlb_flags_t         wr_flags;
    logic [PPN_W-1:0]   sel_ppn;
    logic [IDX_W-1:0]   vict_ptr;
    logic               lk_any;
    logic               rf_present;
    logic               rf_take;
    logic               perm_ok;
    logic               wr_hit;

    // Entry storage and parallel compare
    tlb_entry_array #(
        .ENTRIES(ENTRIES),
        .VPN_W  (VPN_W),
        .PPN_W  (PPN_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vaddr[VA_W-1:PAGE_BITS]),
        .lk_match (lk_match),
        .sel_flags(sel_flags),
        .sel_ppn  (sel_ppn),
        .rf_vpn   (rf_vpn),
        .rf_match (rf_match),
        .wr_en    (wr_en),
        .wr_flags (wr_flags),
        .wr_ppn   (rf_ppn),
        .dirty_set(dirty_set),
        .flush    (flush)
    );

    // Access-rights check on the selected entry
    tlb_perm_check u_perm (
        .flags   (sel_flags),
        .is_write(lk_write),
        .is_user (lk_user),
        .allowed (perm_ok)
    );

    // Round-robin victim choice for new pages
    tlb_victim_ptr #(
        .ENTRIES(ENTRIES)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(rf_take && !rf_present),
        .clear  (flush),
        .ptr    (vict_ptr)
    );

    // Lookup result decode
    always_comb begin
        lk_any   = |lk_match;
        lk_hit   = lk_valid && lk_any && perm_ok;
        lk_fault = lk_valid && lk_any && !perm_ok;
        lk_miss  = lk_valid && !lk_any;
        lk_dirty = lk_valid && lk_any && sel_flags.dty;
        lk_paddr = {sel_ppn, lk_vaddr[PAGE_BITS-1:0]};
    end

    // Refill acceptance: dropped when a flush arrives together
    always_comb begin
        rf_present = |rf_match;
        rf_take    = rf_valid && !flush;
        wr_flags   = '{vld: 1'b1, rd: rf_rd, wr: rf_wr, usr: rf_usr, dty: rf_dirty};
        wr_hit     = lk_hit && lk_write && !sel_flags.dty;
    end

    // Per-entry write enable and dirty-set selection
    for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
        always_comb begin
            if (rf_present) begin
                wr_en[i] = rf_take && rf_match[i];
            end else begin
                wr_en[i] = rf_take && (vict_ptr == IDX_W'(i));
            end
            dirty_set[i] = wr_hit && lk_match[i];
        end
    end

endmodule

// File: rtl/tlb_fa_chk.sv
// Module: property checker bound to the translation buffer top.
// Observes ports, the victim pointer and the refill-present flag.
module tlb_fa_chk #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic             lk_dirty,
    input logic             rf_valid,
    input logic             flush,
    input logic             rf_present,
    input logic [IDX_W-1:0] ptr
);

    logic [IDX_W-1:0] ptr_next;

    // Expected pointer value after one allocating refill
    always_comb begin
        ptr_next = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end

    // R3
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_dirty));

    // R10
    flush_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr == '0));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 lk_valid |-> lk_miss);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !flush && !rf_present) |=> (ptr == $past(ptr_next)));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !flush && rf_present) |=> $stable(ptr));

endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_fault  (lk_fault),
    .lk_dirty  (lk_dirty),
    .rf_valid  (rf_valid),
    .flush     (flush),
    .rf_present(rf_present),
    .ptr       (vict_ptr)
);

// File: tb/tlb_fa_test.sv
module tlb_fa_test;

    localparam int ENT = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write, lk_user;
    logic [31:0] lk_vaddr;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty;
    logic [31:0] lk_paddr;
    logic        rf_valid, rf_rd, rf_wr, rf_usr, rf_dirty, flush;
    logic [19:0] rf_vpn, rf_ppn;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    bit          m_v  [ENT];
    bit          m_rd [ENT];
    bit          m_wr [ENT];
    bit          m_usr[ENT];
    bit          m_d  [ENT];
    logic [19:0] m_tag[ENT];
    logic [19:0] m_ppn[ENT];
    int          m_ptr;

    always #10 clk = ~clk;

    tlb_fa uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_dirty(lk_dirty),
        .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_rd(rf_rd),
        .rf_wr(rf_wr), .rf_usr(rf_usr), .rf_dirty(rf_dirty), .flush(flush)
    );

    task automatic chk(input string tag, input string name, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", tag, name, act, exp);
        end
    endtask

    // One clock: compare outputs against the model, then advance the model
    task automatic step(input string tag);
        bit any = 0;
        int idx = 0;
        bit ok, e_hit;
        #5;
        for (int i = 0; i < ENT; i++)
            if (m_v[i] && m_tag[i] == lk_vaddr[31:12]) begin any = 1; idx = i; end
        ok    = any && (lk_write ? m_wr[idx] : m_rd[idx]) && (!lk_user || m_usr[idx]);
        e_hit = lk_valid && any && ok;
        chk(tag, "hit",   {31'd0, lk_hit},   {31'd0, e_hit});
        chk(tag, "miss",  {31'd0, lk_miss},  {31'd0, lk_valid && !any});
        chk(tag, "fault", {31'd0, lk_fault}, {31'd0, lk_valid && any && !ok});
        chk(tag, "dirty", {31'd0, lk_dirty}, {31'd0, lk_valid && any && m_d[idx]});
        if (e_hit) chk(tag, "paddr", lk_paddr, {m_ppn[idx], lk_vaddr[11:0]});
        @(posedge clk);
        if (flush) begin
            for (int i = 0; i < ENT; i++) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            bit found = 0;
            int slot  = m_ptr;
            if (e_hit && lk_write) m_d[idx] = 1;
            if (rf_valid) begin
                for (int i = 0; i < ENT; i++)
                    if (m_v[i] && m_tag[i] == rf_vpn) begin found = 1; slot = i; end
                m_v[slot] = 1; m_tag[slot] = rf_vpn; m_ppn[slot] = rf_ppn;
                m_rd[slot] = rf_rd; m_wr[slot] = rf_wr; m_usr[slot] = rf_usr;
                m_d[slot] = rf_dirty;
                if (!found) m_ptr = (m_ptr + 1) % ENT;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        lk_valid = 0; lk_write = 0; lk_user = 0; lk_vaddr = '0;
        rf_valid = 0; rf_vpn = '0; rf_ppn = '0; rf_rd = 0; rf_wr = 0;
        rf_usr = 0; rf_dirty = 0; flush = 0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                        input bit wr, input bit usr, input string tag);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_write = wr; lk_user = usr;
        step(tag);
        idle();
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn,
                          input bit rd, input bit wr, input bit usr, input string tag);
        rf_valid = 1; rf_vpn = vpn; rf_ppn = ppn; rf_rd = rd; rf_wr = wr;
        rf_usr = usr; rf_dirty = 0;
        step(tag);
        idle();
    endtask

    initial begin
        for (int i = 0; i < ENT; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_usr[i] = 0;
            m_tag[i] = '0; m_ppn[i] = '0;
        end
        m_ptr = 0;
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        look(20'h00000, 12'h000, 0, 0, "R1");
        look(20'h12345, 12'h678, 1, 1, "R1");
        look(20'hFFFFF, 12'hFFF, 0, 1, "R1");

        // R4: no request, no outcome
        lk_vaddr = 32'h12345678; step("R4"); idle();

        // R2, R3: basic translation
        refill(20'h0000A, 20'hABCDE, 1, 1, 1, "R5");
        look(20'h0000A, 12'h123, 0, 1, "R2");
        look(20'h0000A, 12'hFFF, 0, 0, "R3");

        // R6: read-only and write-only entries
        refill(20'h0000B, 20'h0BBBB, 1, 0, 1, "R5");
        look(20'h0000B, 12'h010, 1, 0, "R6");
        look(20'h0000B, 12'h010, 0, 0, "R6");
        refill(20'h0000D, 20'h0DDDD, 0, 1, 1, "R5");
        look(20'h0000D, 12'h020, 0, 1, "R6");

        // R7: kernel-only entry
        refill(20'h0000C, 20'h0CCCC, 1, 1, 0, "R5");
        look(20'h0000C, 12'h004, 0, 1, "R7");
        look(20'h0000C, 12'h004, 0, 0, "R7");

        // R8: first write sets dirty, visible next lookup
        look(20'h0000A, 12'h008, 1, 0, "R8");
        look(20'h0000A, 12'h008, 0, 0, "R8");

        // R12: faulted and missed writes leave dirty clear
        look(20'h0000B, 12'h000, 1, 0, "R12");
        look(20'h0000C, 12'h000, 1, 1, "R12");
        look(20'h00077, 12'h000, 1, 0, "R12");
        look(20'h0000B, 12'h000, 0, 0, "R12");
        look(20'h0000C, 12'h000, 0, 0, "R12");

        // R9: repeated refill overwrites in place
        refill(20'h0000A, 20'h55555, 1, 1, 1, "R9");
        look(20'h0000A, 12'h3AB, 0, 1, "R9");

        // R5: fill with ENT new pages; the oldest four get evicted
        for (int k = 0; k < ENT; k++)
            refill(20'h10000 + 20'(k), 20'h80000 + 20'(k), 1, 1, 1, "R5");
        look(20'h0000A, 12'h000, 0, 0, "R5");
        look(20'h0000B, 12'h000, 0, 0, "R5");
        look(20'h10000, 12'h111, 0, 0, "R5");
        look(20'h1003F, 12'h222, 0, 0, "R5");

        // R11: lookup and refill of the same page in one cycle
        lk_valid = 1; lk_vaddr = {20'h20000, 12'h040}; lk_write = 0; lk_user = 0;
        rf_valid = 1; rf_vpn = 20'h20000; rf_ppn = 20'h33333; rf_rd = 1; rf_wr = 1; rf_usr = 1;
        step("R11"); idle();
        look(20'h20000, 12'h040, 0, 0, "R11");

        // R11: flush together with a lookup still sees old contents
        lk_valid = 1; lk_vaddr = {20'h20000, 12'h044}; flush = 1;
        step("R11"); idle();
        look(20'h20000, 12'h044, 0, 0, "R10");
        look(20'h1003F, 12'h000, 0, 0, "R10");

        // R10: flush wins over a refill in the same cycle
        refill(20'h30000, 20'h44444, 1, 1, 1, "R10");
        flush = 1; rf_valid = 1; rf_vpn = 20'h30001; rf_ppn = 20'h44445;
        rf_rd = 1; rf_wr = 1; rf_usr = 1;
        step("R10"); idle();
        look(20'h30001, 12'h000, 0, 0, "R10");
        look(20'h30000, 12'h000, 0, 0, "R10");
        refill(20'h30002, 20'h46464, 1, 1, 1, "R10");
        look(20'h30002, 12'h9A0, 1, 1, "R10");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule